// File: doc/BRIEF.md
# Chained Reply Token Arbiter

This block lives in every target on a shared full-duplex serial bus. The host sends a batch of short commands, and broadcast commands reach all targets at once. Each target queues its replies locally. All targets send those replies back on one shared return pair. A token travels down a chain of boards and decides who may drive that pair. The host raises the chain flag when a batch begins and drops it once the final reply has arrived.

A target that receives the token drives its line-driver enable and streams every byte waiting in its reply queue into the local UART transmitter. It then waits until the UART has shifted out the last stop bit, releases the driver and raises its token output for the next board. A target with an empty queue forwards the token within a few clocks. When the host drops the flag, every board releases the token. Bytes that were not sent stay queued for the next round.

The token input comes from another board with an unrelated clock, so it passes through a synchronizer first. A round guard allows the block to take the token only once per round. A fresh round is recognised only after the synchronized token has stayed low long enough.

Top module: `tok_chain_arbiter`

## Requirements
- R1: With an empty reply queue, `tok_out` rises on the (SYNC_STAGES+1)-th rising clock edge after the edge that first samples `tok_in` high. This is the 3rd edge with the default of 2 synchronizer stages.
- R2: With pending bytes, `drv_en` rises at that same edge. The queue bytes are then offered on `tx_valid`/`tx_data` in queue order. A byte transfers, and `rq_pop` is high, in every cycle where `tx_valid` and `tx_ready` are both high. The token is kept until the queue is empty.
- R3: After the last byte is accepted, `drv_en` stays high until a clock edge samples `tx_busy` low. `tok_out` rises at that same edge. `drv_en` and `tok_out` are never high together.
- R4: `tx_valid` is high only while the block holds the token with a non-empty queue and a high synchronized token. `drv_en` is high only from token take until the UART is idle.
- R5: When `tok_in` drops, `tok_out` falls on the (SYNC_STAGES+1)-th rising edge after the edge that first samples it low.
- R6: If `tok_in` drops while bytes are still queued, no further byte is offered. `drv_en` stays high until `tx_busy` is low and then falls without raising `tok_out`. The remaining bytes stay queued and go out first in the next round.
- R7: Once the token has been taken, a new rise of the synchronized token is ignored (no `drv_en`, no `tok_out`) unless the synchronized token was low at REARM_CYCLES consecutive edges before it. Bytes queued after the token was passed wait for the next round.
- R8: During and right after reset, `tok_out`, `drv_en`, `tx_valid` and `rq_pop` are low.
- R9: While `tx_valid` is high, `tx_data` equals `rq_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in | input | 1 | Token from the upstream board (asynchronous) |
| tok_out | output | 1 | Token to the downstream board |
| drv_en | output | 1 | Enable for the shared reply line driver |
| rq_valid | input | 1 | Reply queue holds at least one byte |
| rq_data | input | DATA_W | Head byte of the reply queue |
| rq_pop | output | 1 | Removes the head byte from the queue |
| tx_valid | output | 1 | Byte offered to the UART transmitter |
| tx_data | output | DATA_W | Byte offered to the UART transmitter |
| tx_ready | input | 1 | UART can accept a byte this cycle |
| tx_busy | input | 1 | UART is shifting, high from the cycle after an accept through the final stop bit |

## Verification
The bench goes after the release boundary. If `drv_en` fell when the last byte was accepted instead of when `tx_busy` cleared, it would cut off the stop bit and overlap the next driver. The bench also drops the host flag halfway through a reply, where a faulty design would keep pulling bytes, pass the token or lose the unsent tail. A short low pulse of exactly REARM_CYCLES-1 synchronized cycles probes the round guard, which would otherwise let a board reply twice in one round. Each run is compared every clock against a behavioural model, so an off-by-one in synchronizer depth or state latency shows up as a mismatch on `tok_out` or `drv_en`.

// File: rtl/tca_pkg.sv
`timescale 1ns/1ps
package tca_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_PASS  = 2'd3
   } arb_state_t;
endpackage

// File: rtl/tca_sync.sv
`timescale 1ns/1ps
module tca_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      assert (STAGES >= 2) else $error("tca_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tca_round_guard.sv
`timescale 1ns/1ps
module tca_round_guard #(
   parameter int REARM_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tok_s,
   input  logic take,
   output logic spent
);
   localparam int CW = $clog2(REARM_CYCLES + 1);

   initial begin
      assert (REARM_CYCLES >= 1) else $error("tca_round_guard: REARM_CYCLES must be at least 1");
   end

   logic rearm;

   generate
      if (REARM_CYCLES == 1) begin : g_direct
         assign rearm = !tok_s;
      end else begin : g_count
         logic [CW-1:0] low_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           low_q <= '0;
            else if (tok_s)                       low_q <= '0;
            else if (low_q != CW'(REARM_CYCLES))  low_q <= low_q + 1'b1;
         end
         assign rearm = !tok_s && (low_q >= CW'(REARM_CYCLES - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     spent <= 1'b0;
      else if (take)  spent <= 1'b1;
      else if (rearm) spent <= 1'b0;
   end

   // R7: a round is taken only while the guard is open
   p_take_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !spent);
   // R7: the guard closes after a take
   p_close_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> spent);
endmodule

// File: rtl/tca_reply_fsm.sv
`timescale 1ns/1ps
module tca_reply_fsm
   import tca_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tok_s,
   input  logic spent,
   input  logic rq_valid,
   input  logic tx_ready,
   input  logic tx_busy,
   output logic take,
   output logic drv_en,
   output logic tok_out,
   output logic tx_valid,
   output logic rq_pop
);
   arb_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      take = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (tok_s && !spent) begin
               take = 1'b1;
               st_d = rq_valid ? ST_SEND : ST_PASS;
            end
         end
         ST_SEND:  if (!tok_s || !rq_valid) st_d = ST_DRAIN;
         ST_DRAIN: if (!tx_busy)            st_d = tok_s ? ST_PASS : ST_IDLE;
         ST_PASS:  if (!tok_s)              st_d = ST_IDLE;
         default:                           st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign drv_en   = (st_q == ST_SEND) || (st_q == ST_DRAIN);
   assign tok_out  = (st_q == ST_PASS);
   assign tx_valid = (st_q == ST_SEND) && rq_valid && tok_s;
   assign rq_pop   = tx_valid && tx_ready;

   // R3: driver enable and token output never overlap
   p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_en && tok_out));
   // R3: the driver stays on while the UART still shifts
   p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && tx_busy) |=> drv_en);
   // R3: the token leaves only once the UART was idle
   p_pass_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tok_out) |-> $past(!tx_busy));
   // R5: a low synchronized token removes token out next cycle
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_s |=> !tok_out);
   // R6: no byte is pulled once the token is gone
   p_no_pop_untok_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rq_pop |-> tok_s);
endmodule

// File: rtl/tok_chain_arbiter.sv
`timescale 1ns/1ps
module tok_chain_arbiter #(
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int REARM_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_in,
   output logic              tok_out,
   output logic              drv_en,
   input  logic              rq_valid,
   input  logic [DATA_W-1:0] rq_data,
   output logic              rq_pop,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              tx_busy
);
   initial begin
      assert (DATA_W >= 1) else $error("tok_chain_arbiter: DATA_W must be positive");
   end

   logic tok_s;
   logic spent;
   logic take;

   tca_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(tok_in), .q(tok_s)
   );

   tca_round_guard #(.REARM_CYCLES(REARM_CYCLES)) guard_i (
      .clk(clk), .rst_n(rst_n), .tok_s(tok_s), .take(take), .spent(spent)
   );

   tca_reply_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .tok_s(tok_s), .spent(spent),
      .rq_valid(rq_valid), .tx_ready(tx_ready), .tx_busy(tx_busy),
      .take(take), .drv_en(drv_en), .tok_out(tok_out),
      .tx_valid(tx_valid), .rq_pop(rq_pop)
   );

   assign tx_data = rq_data;

   // R7: the driver turns on only at the first take of a round
   p_one_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> !$past(spent));
   // R4: bytes are offered only while the driver is on
   p_offer_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (drv_en && rq_valid));
endmodule

// File: tb/tok_chain_arbiter_tb_top.sv
`timescale 1ns/1ps
module tok_chain_arbiter_tb_top;
   localparam int DW    = 8;
   localparam int REARM = 4;
   localparam int M_IDLE = 0, M_SEND = 1, M_DRAIN = 2, M_PASS = 3;

   logic clk = 1'b0;
   logic rst_n, tok_in, tok_out, drv_en, rq_valid, rq_pop, tx_valid, tx_ready, tx_busy;
   logic [DW-1:0] rq_data, tx_data;

   always #2 clk = ~clk;

   tok_chain_arbiter #(.DATA_W(DW), .SYNC_STAGES(2), .REARM_CYCLES(REARM)) dut_i (
      .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_out(tok_out), .drv_en(drv_en),
      .rq_valid(rq_valid), .rq_data(rq_data), .rq_pop(rq_pop),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_busy(tx_busy)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   // behavioural reference state
   logic [DW-1:0] q[$];
   logic [DW-1:0] sent[$];
   logic tok_drv = 1'b0;
   logic ms1 = 1'b0, ms2 = 1'b0;
   int   st = M_IDLE;
   bit   spent = 0;
   int   low = 0;
   int   ucnt = 0;
   int   ubyte = 10;
   bit   tok_seen = 0, drv_seen = 0;

   task automatic check(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
      end
   endtask

   task automatic check_int(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic step();
      logic exp_txv, acc;
      int nst;
      @(negedge clk);
      check(tok_out, st == M_PASS, "R1 tok_out vs model");
      check(drv_en, (st == M_SEND) || (st == M_DRAIN), "R3 drv_en vs model");
      check(drv_en && tok_out, 1'b0, "R3 overlap");
      if (tok_out) tok_seen = 1;
      if (drv_en)  drv_seen = 1;
      tok_in   = tok_drv;
      tx_ready = (ucnt == 0);
      tx_busy  = (ucnt != 0);
      rq_valid = (q.size() > 0);
      rq_data  = (q.size() > 0) ? q[0] : '0;
      #1;
      exp_txv = (st == M_SEND) && ms2 && (q.size() > 0);
      acc     = exp_txv && (ucnt == 0);
      check(tx_valid, exp_txv, "R4 tx_valid vs model");
      check(rq_pop, acc, "R2 rq_pop vs model");
      if (exp_txv) check_int(int'(tx_data), int'(q[0]), "R9 tx_data");
      nst = st;
      case (st)
         M_IDLE:  if (ms2 && !spent) nst = (q.size() > 0) ? M_SEND : M_PASS;
         M_SEND:  if (!ms2 || q.size() == 0) nst = M_DRAIN;
         M_DRAIN: if (ucnt == 0) nst = ms2 ? M_PASS : M_IDLE;
         default: if (!ms2) nst = M_IDLE;
      endcase
      if (st == M_IDLE && ms2 && !spent) spent = 1;
      else if (!ms2 && low >= REARM - 1) spent = 0;
      if (ms2) low = 0; else if (low < REARM) low++;
      st  = nst;
      ms2 = ms1;
      ms1 = tok_drv;
      if (acc) begin
         ucnt = ubyte;
         sent.push_back(q.pop_front());
      end else if (ucnt > 0) ucnt--;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_tok(input string what);
      for (int i = 0; i < 400; i++) begin
         step();
         if (tok_out) return;
      end
      check(1'b0, 1'b1, what);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tok_in = 1'b0; rq_valid = 1'b0; rq_data = '0;
      tx_ready = 1'b1; tx_busy = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(tok_out, 1'b0, "R8 reset tok_out");
      check(drv_en, 1'b0, "R8 reset drv_en");
      check(tx_valid, 1'b0, "R8 reset tx_valid");
      check(rq_pop, 1'b0, "R8 reset rq_pop");
      rst_n = 1'b1;

      // empty queue: fast pass-through (R1) and release (R5)
      tok_drv = 1'b1;
      step(); step(); settle();
      check(tok_out, 1'b0, "R1 tok_out not before third edge");
      step(); settle();
      check(tok_out, 1'b1, "R1 tok_out on third edge");
      check(drv_en, 1'b0, "R1 no drive with empty queue");
      tok_drv = 1'b0;
      step(); step(); settle();
      check(tok_out, 1'b1, "R5 tok_out held before third edge");
      step(); settle();
      check(tok_out, 1'b0, "R5 tok_out dropped on third edge");
      run(8);

      // three replies sent in order, then token passed (R2, R3)
      q.push_back(8'h41); q.push_back(8'hB2); q.push_back(8'h0C);
      sent.delete();
      tok_drv = 1'b1;
      wait_tok("R3 token passed after replies");
      check_int(sent.size(), 3, "R2 bytes sent");
      if (sent.size() == 3) begin
         check_int(int'(sent[0]), 'h41, "R2 order byte0");
         check_int(int'(sent[1]), 'hB2, "R2 order byte1");
         check_int(int'(sent[2]), 'h0C, "R2 order byte2");
      end
      check_int(q.size(), 0, "R2 queue drained");
      tok_drv = 1'b0;
      run(10);

      // host drops the flag mid-reply (R6)
      for (int b = 0; b < 5; b++) q.push_back(8'(8'h10 + b));
      sent.delete();
      tok_seen = 0;
      tok_drv = 1'b1;
      for (int i = 0; i < 400 && sent.size() < 2; i++) step();
      tok_drv = 1'b0;
      run(40);
      check_int(sent.size(), 2, "R6 no byte after flag drop");
      check_int(q.size(), 3, "R6 unsent bytes kept");
      check(tok_seen, 1'b0, "R6 no token pass on abort");
      check(drv_en, 1'b0, "R6 driver released after abort");

      // next round: leftovers first; then a short low pulse is ignored (R7)
      sent.delete();
      tok_drv = 1'b1;
      wait_tok("R6 token passed in next round");
      check_int(sent.size(), 3, "R6 leftovers sent");
      if (sent.size() == 3) begin
         check_int(int'(sent[0]), 'h12, "R6 leftover byte0");
         check_int(int'(sent[2]), 'h14, "R6 leftover byte2");
      end
      q.push_back(8'h55);
      run(3);
      check_int(q.size(), 1, "R7 late reply waits while passed");
      tok_drv = 1'b0;
      run(REARM - 1);
      tok_drv = 1'b1;
      run(4);
      tok_seen = 0; drv_seen = 0;
      run(25);
      check(tok_seen, 1'b0, "R7 short low pulse gives no token");
      check(drv_seen, 1'b0, "R7 short low pulse gives no drive");
      check_int(q.size(), 1, "R7 reply held for next round");

      // full rearm with a fast UART: back-to-back bytes (R7, R2)
      tok_drv = 1'b0;
      run(10);
      ubyte = 1;
      q.push_back(8'hA0); q.push_back(8'hA1); q.push_back(8'hA2);
      sent.delete();
      tok_drv = 1'b1;
      wait_tok("R7 rearmed round passes token");
      check_int(sent.size(), 4, "R7 held reply sent after rearm");
      if (sent.size() == 4) begin
         check_int(int'(sent[0]), 'h55, "R7 held reply first");
         check_int(int'(sent[3]), 'hA2, "R2 fast UART last byte");
      end
      tok_drv = 1'b0;
      run(10);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule